// File: doc/BRIEF.md
# Performance Counter with Threshold Compare

This block is a single performance-monitoring counter. It has a 36-bit accumulator and two 36-bit thresholds. Each cycle that counting is enabled, the counter takes an event increment. In its sampling mode it instead loads an instantaneous queue-occupancy value. Two registered status bits report how the count stands against each threshold. One control bit sets the polarity of both tests: either "count above threshold" or "count at or below threshold".

Counting can be gated in two ways. The first is a plain enable pin. The second is an enable that a queue-empty event latches on and a queue-non-empty event turns off. A clear-source level resets the counter in one of two ways. It can act as a level, or it can act through an edge detector that produces exactly one clear cycle for each rising edge.

Software reaches the block through a 32-bit write port. Each 36-bit quantity is split into a 32-bit low word and a 4-bit high nibble.

The increment, queue and event inputs carry no valid/ready handshake. The block accepts a new sample on every clock and never applies back-pressure. An upstream source must therefore present each sample for exactly the cycles it should be counted.

Top module: `perf_threshold_counter`

## Requirements
- R1: After reset, the count and the overflow flag are 0, both status bits are 0, all control bits are 0, each threshold's high nibble is 0xF and each threshold's low word is 0.
- R2: With sampling mode off, each clock with counting enabled adds `incr_i`, zero-extended, to the count, modulo 2^36.
- R3: A carry out of bit 35 during accumulation sets the sticky `overflow_o`. Writing a 1 to control bit 8 (address 5) clears it. A wrap in the same cycle as that write wins, and the flag stays set.
- R4: With sampling mode on (control bit 1), each enabled clock loads `incr_i` into the count and never sets overflow.
- R5: With control bit 2 clear, `cnt_en_i` enables counting. With it set, the latched enable is used and `cnt_en_i` has no effect.
- R6: The latched enable is set by `q_empty_i` and cleared by `q_nonempty_i` or by a counter clear. Clearing has priority over setting. The change applies from the next clock.
- R7: With control bit 3 clear, the count is forced to 0 on every clock while `clr_src_i` is high.
- R8: With control bit 3 set, a rising edge of `clr_src_i` clears the count for exactly one clock. Counting resumes while the source stays high.
- R9: `status_o[k]` updates one clock after the count and threshold k. With control bit 0 clear it is 1 when the count exceeds threshold k. With bit 0 set it is 1 when the count is less than or equal to threshold k.
- R10: Writes take effect on the next clock. The address map is: 0 = count low word, 1 = count bits [35:32] from data [3:0], 2 and 3 = low words of thresholds 0 and 1, 4 = threshold high nibbles (threshold 0 at data [3:0], threshold 1 at data [11:8]), 5 = control. Precedence is clear over count write over accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| cnt_en_i | input | 1 | Direct count enable |
| incr_i | input | 16 | Event increment or queue-occupancy sample |
| q_empty_i | input | 1 | Queue-empty event, sets latched enable |
| q_nonempty_i | input | 1 | Queue-non-empty event, clears latched enable |
| clr_src_i | input | 1 | Counter clear source level |
| count_o | output | 36 | Current count |
| overflow_o | output | 1 | Sticky wrap flag |
| status_o | output | 2 | Threshold status, bit k against threshold k |

## Verification
The bench targets several corner cases, and each one shows a specific wrong design:

- **Equality.** The bench sets the count exactly equal to a threshold. An off-by-one comparator would report above-threshold there, or fail to report at-or-below.
- **Wrap at the 36-bit boundary.** The bench forces the count to its top value. A 32-bit carry would wrap early, and a missing sticky flag would lose the overflow.
- **Pulsed clear.** The bench holds the clear source high over several cycles. A level-sensitive design would keep the count at zero instead of letting it resume.
- **Collisions and gating.** The bench fires writes, clears and events in the same cycle, which exposes a wrong precedence. It also checks that queue-empty events gate counting only when the latched enable is selected.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [2:0] {
    A_CNT_LO  = 3'd0,
    A_CNT_HI  = 3'd1,
    A_CMP0_LO = 3'd2,
    A_CMP1_LO = 3'd3,
    A_CMP_HI  = 3'd4,
    A_CTRL    = 3'd5
  } ptc_addr_e;

  // control word, bit 0 is not_gt
  typedef struct packed {
    logic pulse_clr;
    logic lat_sel;
    logic add_zero;
    logic not_gt;
  } ptc_ctrl_t;

  localparam int CTRL_W      = 4;
  localparam int OVF_W1C_BIT = 8;
  localparam int HI_STRIDE   = 8;  // spacing of threshold nibbles in A_CMP_HI
  localparam int N_CMP       = 2;
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int CNT_W = 36,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output ptc_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] cmp0_o,
  output logic [CNT_W-1:0] cmp1_o,
  output logic             wr_lo_o,
  output logic             wr_hi_o,
  output logic             ovf_w1c_o
);
  localparam int HI_W = CNT_W - DW;

  logic [CNT_W-1:0] cmp_q [N_CMP];

  assign wr_lo_o   = wr_en && (wr_addr == A_CNT_LO);
  assign wr_hi_o   = wr_en && (wr_addr == A_CNT_HI);
  assign ovf_w1c_o = wr_en && (wr_addr == A_CTRL) && wr_data[OVF_W1C_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_o <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl_o <= ptc_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    localparam logic [2:0] LO_ADDR = 3'(A_CMP0_LO) + 3'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[g] <= {{HI_W{1'b1}}, {DW{1'b0}}};
      end else if (wr_en) begin
        if (wr_addr == LO_ADDR)
          cmp_q[g][DW-1:0] <= wr_data;
        if (wr_addr == A_CMP_HI)
          cmp_q[g][CNT_W-1:DW] <= wr_data[g*HI_STRIDE +: HI_W];
      end
    end
  end

  assign cmp0_o = cmp_q[0];
  assign cmp1_o = cmp_q[1];
endmodule

// File: rtl/ptc_gate.sv
module ptc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic lat_sel,
  input  logic cnt_en_i,
  input  logic q_empty_i,
  input  logic q_nonempty_i,
  input  logic clr_src_i,
  output logic clr_o,
  output logic en_o
);
  logic src_d, lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_d <= 1'b0;
    else        src_d <= clr_src_i;
  end

  assign clr_o = pulse_mode ? (clr_src_i & ~src_d) : clr_src_i;
  assign en_o  = lat_sel ? lat_q : cnt_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n)            lat_q <= 1'b0;
    else if (clr_o)        lat_q <= 1'b0;
    else if (q_nonempty_i) lat_q <= 1'b0;
    else if (q_empty_i)    lat_q <= 1'b1;
  end

  // a pulsed clear never lasts two cycles while the mode is held
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && $past(pulse_mode) && $past(clr_o)) |-> !clr_o);

  // a lone empty event latches the enable
  assert_lat_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_empty_i && !q_nonempty_i && !clr_o) |-> lat_q);

  // any clear drops the latched enable
  assert_lat_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_o) |-> !lat_q);
endmodule

// File: rtl/ptc_accum.sv
module ptc_accum #(
  parameter int CNT_W = 36,
  parameter int DW    = 32,
  parameter int IN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             add_zero,
  input  logic [IN_W-1:0]  incr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wr_data,
  input  logic             ovf_w1c,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int HI_W = CNT_W - DW;

  logic [CNT_W-1:0] incr_x;
  logic [CNT_W:0]   sum;
  logic             acc, wrap;

  assign incr_x = {{(CNT_W-IN_W){1'b0}}, incr};
  assign sum    = {1'b0, cnt_o} + {1'b0, incr_x};
  assign acc    = en && !clr && !wr_lo && !wr_hi;
  assign wrap   = acc && !add_zero && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr)    cnt_o <= '0;
    else if (wr_lo)  cnt_o[DW-1:0] <= wr_data;
    else if (wr_hi)  cnt_o[CNT_W-1:DW] <= wr_data[HI_W-1:0];
    else if (en)     cnt_o <= add_zero ? incr_x : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_o <= 1'b0;
    else if (wrap)    ovf_o <= 1'b1;
    else if (ovf_w1c) ovf_o <= 1'b0;
  end

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> $past(ovf_w1c));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> cnt_o == '0);

  assert_addzero_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && add_zero) |-> (cnt_o == $past(incr_x)) && !$rose(ovf_o));
endmodule

// File: rtl/ptc_cmp.sv
module ptc_cmp #(
  parameter int CNT_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             not_gt,
  output logic             status_o
);
  logic above;
  assign above = cnt > thr;

  always_ff @(posedge clk) begin
    if (!rst_n) status_o <= 1'b0;
    else        status_o <= not_gt ? !above : above;
  end

  // at equality the status equals the polarity bit
  assert_status_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cnt == thr) |-> status_o == $past(not_gt));
endmodule

// File: rtl/perf_threshold_counter.sv
module perf_threshold_counter
  import ptc_pkg::*;
#(
  parameter int CNT_W = 36,
  parameter int DW    = 32,
  parameter int IN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             cnt_en_i,
  input  logic [IN_W-1:0]  incr_i,
  input  logic             q_empty_i,
  input  logic             q_nonempty_i,
  input  logic             clr_src_i,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o,
  output logic [N_CMP-1:0] status_o
);
  ptc_ctrl_t        ctrl;
  logic [CNT_W-1:0] thr [N_CMP];
  logic             wr_lo, wr_hi, w1c, clr, en;

  ptc_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .ctrl_o(ctrl), .cmp0_o(thr[0]), .cmp1_o(thr[1]),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .ovf_w1c_o(w1c)
  );

  ptc_gate u_gate (
    .clk, .rst_n,
    .pulse_mode(ctrl.pulse_clr), .lat_sel(ctrl.lat_sel),
    .cnt_en_i, .q_empty_i, .q_nonempty_i, .clr_src_i,
    .clr_o(clr), .en_o(en)
  );

  ptc_accum #(.CNT_W(CNT_W), .DW(DW), .IN_W(IN_W)) u_acc (
    .clk, .rst_n, .clr, .en, .add_zero(ctrl.add_zero), .incr(incr_i),
    .wr_lo, .wr_hi, .wr_data, .ovf_w1c(w1c),
    .cnt_o(count_o), .ovf_o(overflow_o)
  );

  for (genvar k = 0; k < N_CMP; k++) begin : g_stat
    ptc_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk, .rst_n, .cnt(count_o), .thr(thr[k]),
      .not_gt(ctrl.not_gt), .status_o(status_o[k])
    );
  end

  // R5: with the latched path selected the direct enable cannot start counting
  assert_enable_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl.lat_sel && !en && !clr && !wr_lo && !wr_hi) |-> $stable(count_o));
endmodule

// File: tb/sim_perf_threshold_counter.sv
module sim_perf_threshold_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cnt_en_i = 1'b0;
  logic [15:0] incr_i = '0;
  logic        q_empty_i = 1'b0, q_nonempty_i = 1'b0, clr_src_i = 1'b0;
  logic [35:0] count_o;
  logic        overflow_o;
  logic [1:0]  status_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [35:0] m_cnt, m_cmp0, m_cmp1;
  logic        m_ovf, m_lat, m_srcd;
  logic [1:0]  m_st;
  logic [3:0]  m_ctrl;

  always #10ns clk = ~clk;

  perf_threshold_counter u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cnt_en_i, .incr_i,
    .q_empty_i, .q_nonempty_i, .clr_src_i, .count_o, .overflow_o, .status_o
  );

  function automatic logic st_of(logic [35:0] c, logic [35:0] t, logic ng);
    return ng ? (c <= t) : (c > t);
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " count"}, count_o, m_cnt);
    chk({tag, " overflow"}, 36'(overflow_o), 36'(m_ovf));
    chk({tag, " status"}, 36'(status_o), 36'(m_st));
  endtask

  // drive one cycle at the falling edge, advance the model, then check outputs
  task automatic step(bit en, logic [15:0] inc, bit qe, bit qn, bit src,
                      bit we, logic [2:0] wa, logic [31:0] wd, string tag);
    logic clr, ee, wrap, w1c;
    logic [36:0] sum;
    logic [35:0] n_cnt, n_c0, n_c1;
    logic n_ovf, n_lat;
    logic [3:0] n_ctrl;
    cnt_en_i = en; incr_i = inc; q_empty_i = qe; q_nonempty_i = qn;
    clr_src_i = src; wr_en = we; wr_addr = wa; wr_data = wd;
    clr  = m_ctrl[3] ? (src & ~m_srcd) : src;
    ee   = m_ctrl[2] ? m_lat : en;
    sum  = {1'b0, m_cnt} + 37'(inc);
    wrap = 1'b0;
    n_cnt = m_cnt;
    if (clr) n_cnt = '0;
    else if (we && wa == 3'd0) n_cnt[31:0] = wd;
    else if (we && wa == 3'd1) n_cnt[35:32] = wd[3:0];
    else if (ee) begin
      if (m_ctrl[1]) n_cnt = 36'(inc);
      else begin n_cnt = sum[35:0]; wrap = sum[36]; end
    end
    w1c   = we && wa == 3'd5 && wd[8];
    n_ovf = wrap ? 1'b1 : (w1c ? 1'b0 : m_ovf);
    n_lat = clr ? 1'b0 : (qn ? 1'b0 : (qe ? 1'b1 : m_lat));
    n_ctrl = (we && wa == 3'd5) ? wd[3:0] : m_ctrl;
    n_c0 = m_cmp0; n_c1 = m_cmp1;
    if (we && wa == 3'd2) n_c0[31:0] = wd;
    if (we && wa == 3'd3) n_c1[31:0] = wd;
    if (we && wa == 3'd4) begin n_c0[35:32] = wd[3:0]; n_c1[35:32] = wd[11:8]; end
    m_st = {st_of(m_cnt, m_cmp1, m_ctrl[0]), st_of(m_cnt, m_cmp0, m_ctrl[0])};
    @(posedge clk);
    @(negedge clk);
    m_cnt = n_cnt; m_ovf = n_ovf; m_lat = n_lat; m_ctrl = n_ctrl;
    m_cmp0 = n_c0; m_cmp1 = n_c1; m_srcd = src;
    check_all(tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    step(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic run(bit en, logic [15:0] inc, bit src, string tag);
    step(en, inc, 1'b0, 1'b0, src, 1'b0, 3'd0, 32'd0, tag);
  endtask

  initial begin : watchdog
    #(20ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    m_cnt = '0; m_ovf = 0; m_lat = 0; m_srcd = 0; m_st = '0; m_ctrl = '0;
    m_cmp0 = 36'hF_0000_0000; m_cmp1 = 36'hF_0000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count_o, 36'd0);
    chk("R1 overflow", 36'(overflow_o), 36'd0);
    chk("R1 status", 36'(status_o), 36'd0);
    wr(3'd5, 32'h1, "R1");
    run(0, 0, 0, "R1");
    chk("R1 threshold high nibble reset", 36'(status_o), 36'd3);

    // R9 equality and polarity
    wr(3'd4, 32'h0, "R10");
    wr(3'd2, 32'd100, "R10");
    wr(3'd0, 32'd100, "R10");
    wr(3'd5, 32'h0, "R9");
    run(0, 0, 0, "R9");
    chk("R9 gt at equality", 36'(status_o), 36'b10);
    wr(3'd5, 32'h1, "R9");
    run(0, 0, 0, "R9");
    chk("R9 not-gt at equality", 36'(status_o), 36'b01);
    wr(3'd5, 32'h0, "R9");

    // R2 / R3 wrap at 36 bits, sticky, write-one clear
    wr(3'd1, 32'hF, "R10");
    wr(3'd0, 32'hFFFF_FFFE, "R10");
    run(1, 16'd1, 0, "R2");
    chk("R2 top value", count_o, 36'hF_FFFF_FFFF);
    run(1, 16'd3, 0, "R3");
    chk("R3 wrapped count", count_o, 36'd2);
    chk("R3 overflow set", 36'(overflow_o), 36'd1);
    run(0, 0, 0, "R3");
    chk("R3 overflow sticky", 36'(overflow_o), 36'd1);
    wr(3'd5, 32'h100, "R3");
    chk("R3 overflow cleared", 36'(overflow_o), 36'd0);

    // R10 write beats accumulate, clear beats write
    step(1, 16'd9, 0, 0, 0, 1, 3'd0, 32'd77, "R10");
    chk("R10 write over increment", count_o, 36'd77);
    step(1, 16'd9, 0, 0, 1, 1, 3'd0, 32'd55, "R10");
    chk("R10 clear over write", count_o, 36'd0);

    // R4 sampling mode
    wr(3'd5, 32'h2, "R4");
    run(1, 16'h1234, 0, "R4");
    chk("R4 sample load", count_o, 36'h1234);
    run(1, 16'd5, 0, "R4");
    chk("R4 second sample", count_o, 36'd5);

    // R7 level clear
    wr(3'd5, 32'h0, "R7");
    run(1, 16'd4, 0, "R7");
    run(1, 16'd4, 1, "R7");
    run(1, 16'd4, 1, "R7");
    chk("R7 held level clear", count_o, 36'd0);

    // R8 pulsed clear
    wr(3'd5, 32'h8, "R8");
    run(1, 16'd1, 0, "R8");
    run(1, 16'd1, 1, "R8");
    chk("R8 pulse clears", count_o, 36'd0);
    run(1, 16'd1, 1, "R8");
    run(1, 16'd1, 1, "R8");
    chk("R8 counting resumes", count_o, 36'd2);

    // R5 / R6 latched enable
    wr(3'd5, 32'h4, "R5");
    wr(3'd0, 32'd0, "R5");
    run(1, 16'd1, 0, "R5");
    chk("R5 direct enable ignored", count_o, 36'd0);
    step(0, 16'd2, 1, 0, 0, 0, 3'd0, 32'd0, "R6");
    run(0, 16'd2, 0, "R6");
    run(0, 16'd2, 0, "R6");
    chk("R6 latched counting", count_o, 36'd4);
    step(0, 16'd2, 0, 1, 0, 0, 3'd0, 32'd0, "R6");
    run(0, 16'd2, 0, "R6");
    chk("R6 non-empty stops", count_o, 36'd6);
    step(0, 16'd2, 1, 0, 1, 0, 3'd0, 32'd0, "R6");
    run(0, 16'd2, 0, "R6");
    chk("R6 clear beats set", count_o, 36'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [2:0] a;
      logic [31:0] d;
      bit we;
      r  = $urandom;
      we = (r[2:0] == 3'd0);
      a  = 3'($urandom_range(0, 5));
      d  = $urandom;
      if (a == 3'd1) d = {28'd0, 4'hE | 4'(r[3])};
      if (a == 3'd5) d = {23'd0, r[4], 4'd0, r[8:5]};
      step(r[9], 16'($urandom), r[10] & r[11], r[12] & r[13], r[14] & r[15] & r[16],
           we, a, d, "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule